// File: doc/BRIEF.md
# Speculative Load Address Check Table

This block lets a scheduler hoist loads above earlier stores that might write the same memory. When a load is executed early, the block records the load's address together with the tag of the register it wrote. Every store is snooped: its address is compared against all recorded entries at once, and any entry that lies in the same 8-byte granule is invalidated. When the program reaches the point where the load originally stood, a check operation looks up the register tag.

If a valid entry is found, the hoisted value is still good and execution continues. If no valid entry is found, the block raises a fixup request so that the value is reloaded. An entry counts as missing whether a store hit it or it was pushed out for lack of space.

The table is fully associative with a parameterised number of entries. Free slots are filled first. When every slot is valid, the victim is chosen round-robin and the displaced entry is simply lost. A flush input empties the whole table in one cycle.

Top module: `ldchk_table`

## Requirements
- R1: After synchronous reset every entry is invalid, so a check of any tag raises fixup and not hit.
- R2: An insert (with no flush, and no store to the same 8-byte granule in that cycle) makes a check of that tag in any later cycle report hit, as long as nothing has invalidated or displaced the entry.
- R3: A store invalidates a valid entry when address bits [ADDR_W-1:3] of the store equal those of the entry. Address bits [2:0] are ignored. A store to another granule leaves the entry valid.
- R4: A single store invalidates every valid entry in its granule, whatever the tags of those entries.
- R5: A check that hits leaves its entry valid, so repeating the check hits again.
- R6: An insert whose tag matches a valid entry overwrites that entry in place. The old address no longer causes invalidation, the new address does, and no other entry is consumed.
- R7: When all ENTRIES slots are valid and the insert matches no tag, the victim is chosen round-robin, starting at slot 0 after reset or flush. Successive evictions therefore displace the oldest-filled slots in order, and a displaced tag then checks as fixup.
- R8: An insert and a store to the same granule in the same cycle leave the new entry invalid (the insert is applied first, then the store). If the store is to a different granule, the new entry stays valid.
- R9: A flush empties the table in one cycle, takes priority over an insert in the same cycle, and resets the round-robin victim pointer to slot 0.
- R10: The check response is combinational and reflects the table state before any update in that cycle. When chk_valid is high, exactly one of chk_hit and chk_fixup is high; when chk_valid is low, both are low.
- R11: An insert uses the lowest-numbered invalid slot when one exists, so slots freed by stores are reused before any valid entry is evicted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries and reset the victim pointer |
| ins_valid | input | 1 | Advanced load is recording an entry |
| ins_tag | input | TAG_W | Destination register tag of the advanced load |
| ins_addr | input | ADDR_W | Byte address of the advanced load |
| st_valid | input | 1 | Store snoop strobe |
| st_addr | input | ADDR_W | Byte address of the store |
| chk_valid | input | 1 | Check operation request |
| chk_tag | input | TAG_W | Register tag being checked |
| chk_hit | output | 1 | Entry present and valid; speculation succeeded |
| chk_fixup | output | 1 | Entry absent or invalidated; reload required |

## Verification
The bench builds the table with ENTRIES=4, TAG_W=4 and ADDR_W=12. With these values the whole tag space of 16 tags can be swept after every scenario, and the table fills after only four inserts. That puts repeated round-robin eviction, pointer wrap and reuse of freed slots within reach in a few dozen cycles. A long pseudo-random mix of inserts, stores, flushes and checks over eight small address granules follows. It drives same-granule collisions, same-cycle insert/store pairs and tag replacement often, and every response is compared against an arithmetic table model kept in the bench.

// File: rtl/ldchk_pkg.sv
`timescale 1ns/1ps
package ldchk_pkg;

    // Address bits below this position are ignored by the alias compare
    localparam int unsigned GRAN_LSB = 3;

    // How an incoming advanced load obtains its slot
    typedef enum logic [1:0] {
        ALLOC_NONE,
        ALLOC_SAME_TAG,
        ALLOC_FREE,
        ALLOC_EVICT
    } alloc_kind_e;

    // Check port response
    typedef struct packed {
        logic hit;
        logic fixup;
    } chk_resp_t;

endpackage

// File: rtl/ldchk_slot.sv
`timescale 1ns/1ps
module ldchk_slot #(
    parameter int TAG_W  = 7,
    parameter int GRAN_W = 29
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic              wr_kill,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [GRAN_W-1:0] wr_gran,
    input  logic              st_valid,
    input  logic [GRAN_W-1:0] st_gran,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              vld_o,
    output logic              lk_hit_o,
    output logic              same_tag_o
);

    logic              vld_q;
    logic [TAG_W-1:0]  tag_q;
    logic [GRAN_W-1:0] gran_q;
    logic              snoop_hit;

    assign snoop_hit  = st_valid && vld_q && (gran_q == st_gran);
    assign vld_o      = vld_q;
    assign lk_hit_o   = vld_q && (tag_q == lk_tag);
    assign same_tag_o = vld_q && (tag_q == wr_tag);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            vld_q <= 1'b0;
        end else if (wr_en) begin
            // insert first, then a colliding store kills it
            vld_q <= !wr_kill;
        end else if (snoop_hit) begin
            vld_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            tag_q  <= wr_tag;
            gran_q <= wr_gran;
        end
    end

endmodule

// File: rtl/ldchk_alloc.sv
`timescale 1ns/1ps
module ldchk_alloc
    import ldchk_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               ins_valid,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] same_vec,
    output logic [ENTRIES-1:0] wr_vec
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    alloc_kind_e      kind;
    logic [IDX_W-1:0] pick;
    logic [IDX_W-1:0] ptr_q;

    always_comb begin
        kind = ALLOC_NONE;
        pick = '0;
        if (ins_valid && !flush) begin
            if (|same_vec) begin
                kind = ALLOC_SAME_TAG;
                for (int i = ENTRIES - 1; i >= 0; i--) begin
                    if (same_vec[i]) pick = IDX_W'(i);
                end
            end else if (!(&valid_vec)) begin
                kind = ALLOC_FREE;
                for (int i = ENTRIES - 1; i >= 0; i--) begin
                    if (!valid_vec[i]) pick = IDX_W'(i);
                end
            end else begin
                kind = ALLOC_EVICT;
                pick = ptr_q;
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_wr
        assign wr_vec[g] = (kind != ALLOC_NONE) && (pick == IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ptr_q <= '0;
        end else if (kind == ALLOC_EVICT) begin
            ptr_q <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/ldchk_lookup.sv
`timescale 1ns/1ps
module ldchk_lookup
    import ldchk_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic               chk_valid,
    input  logic [ENTRIES-1:0] hit_vec,
    output chk_resp_t          resp
);

    logic found;

    assign found      = |hit_vec;
    assign resp.hit   = chk_valid && found;
    assign resp.fixup = chk_valid && !found;

endmodule

// File: rtl/ldchk_table.sv
`timescale 1ns/1ps
module ldchk_table
    import ldchk_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    parameter int TAG_W   = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              ins_valid,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    output logic              chk_hit,
    output logic              chk_fixup
);

    localparam int GRAN_W = ADDR_W - GRAN_LSB;

    logic [GRAN_W-1:0]  ins_gran;
    logic [GRAN_W-1:0]  st_gran;
    logic               ins_killed;
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] same_vec;
    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] wr_vec;
    chk_resp_t          resp;

    assign ins_gran   = ins_addr[ADDR_W-1:GRAN_LSB];
    assign st_gran    = st_addr[ADDR_W-1:GRAN_LSB];
    assign ins_killed = st_valid && (ins_gran == st_gran);

    ldchk_alloc #(.ENTRIES(ENTRIES)) alloc_i (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .ins_valid (ins_valid),
        .valid_vec (valid_vec),
        .same_vec  (same_vec),
        .wr_vec    (wr_vec)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        ldchk_slot #(.TAG_W(TAG_W), .GRAN_W(GRAN_W)) slot_i (
            .clk        (clk),
            .rst        (rst),
            .clr        (flush),
            .wr_en      (wr_vec[g]),
            .wr_kill    (ins_killed),
            .wr_tag     (ins_tag),
            .wr_gran    (ins_gran),
            .st_valid   (st_valid),
            .st_gran    (st_gran),
            .lk_tag     (chk_tag),
            .vld_o      (valid_vec[g]),
            .lk_hit_o   (hit_vec[g]),
            .same_tag_o (same_vec[g])
        );
    end

    ldchk_lookup #(.ENTRIES(ENTRIES)) lookup_i (
        .chk_valid (chk_valid),
        .hit_vec   (hit_vec),
        .resp      (resp)
    );

    assign chk_hit   = resp.hit;
    assign chk_fixup = resp.fixup;

endmodule

// File: rtl/ldchk_table_chk.sv
`timescale 1ns/1ps
module ldchk_table_chk
    import ldchk_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    parameter int TAG_W   = 7
) (
    input logic               clk,
    input logic               rst,
    input logic               flush,
    input logic               ins_valid,
    input logic [TAG_W-1:0]   ins_tag,
    input logic [ADDR_W-1:0]  ins_addr,
    input logic               st_valid,
    input logic [ADDR_W-1:0]  st_addr,
    input logic               chk_valid,
    input logic [TAG_W-1:0]   chk_tag,
    input logic               chk_hit,
    input logic               chk_fixup,
    input logic [ENTRIES-1:0] valid_vec
);

    logic same_gran;
    assign same_gran = (ins_addr[ADDR_W-1:GRAN_LSB] == st_addr[ADDR_W-1:GRAN_LSB]);

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_vec == '0));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));

    // R10
    resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(chk_hit && chk_fixup));

    // R10
    resp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |-> (!chk_hit && !chk_fixup));

    // R2
    ins_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !flush && !(st_valid && same_gran))
        |=> ((chk_valid && (chk_tag == $past(ins_tag))) |-> chk_hit));

    // R3
    store_no_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !ins_valid && !flush)
        |=> ($countones(valid_vec) <= $past($countones(valid_vec))));

    // R6
    ins_grow_one_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !flush)
        |=> ($countones(valid_vec) <= $past($countones(valid_vec)) + 1));

endmodule

bind ldchk_table ldchk_table_chk #(
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W),
    .TAG_W   (TAG_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .ins_valid (ins_valid),
    .ins_tag   (ins_tag),
    .ins_addr  (ins_addr),
    .st_valid  (st_valid),
    .st_addr   (st_addr),
    .chk_valid (chk_valid),
    .chk_tag   (chk_tag),
    .chk_hit   (chk_hit),
    .chk_fixup (chk_fixup),
    .valid_vec (valid_vec)
);

// File: tb/ldchk_table_tb_top.sv
`timescale 1ns/1ps
module ldchk_table_tb_top;

    localparam int ENTRIES = 4;
    localparam int ADDR_W  = 12;
    localparam int TAG_W   = 4;
    localparam int NTAGS   = 1 << TAG_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              flush;
    logic              ins_valid;
    logic [TAG_W-1:0]  ins_tag;
    logic [ADDR_W-1:0] ins_addr;
    logic              st_valid;
    logic [ADDR_W-1:0] st_addr;
    logic              chk_valid;
    logic [TAG_W-1:0]  chk_tag;
    logic              chk_hit;
    logic              chk_fixup;

    always #2.5 clk = ~clk;

    ldchk_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst(rst), .flush(flush),
        .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_addr(ins_addr),
        .st_valid(st_valid), .st_addr(st_addr),
        .chk_valid(chk_valid), .chk_tag(chk_tag),
        .chk_hit(chk_hit), .chk_fixup(chk_fixup)
    );

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    // Bench table model
    bit                 m_v [ENTRIES];
    logic [TAG_W-1:0]   m_t [ENTRIES];
    logic [ADDR_W-4:0]  m_g [ENTRIES];
    int                 m_ptr;

    function automatic bit m_has(input logic [TAG_W-1:0] t);
        for (int i = 0; i < ENTRIES; i++)
            if (m_v[i] && m_t[i] == t) return 1'b1;
        return 1'b0;
    endfunction

    task automatic cyc(input bit ins, input logic [TAG_W-1:0] it, input logic [ADDR_W-1:0] ia,
                       input bit st, input logic [ADDR_W-1:0] sa, input bit fl,
                       input bit ck, input logic [TAG_W-1:0] ct, input string req);
        bit exp_h, exp_f;
        int w;
        ins_valid = ins; ins_tag = it; ins_addr = ia;
        st_valid = st; st_addr = sa; flush = fl;
        chk_valid = ck; chk_tag = ct;
        #1;
        exp_h = ck && m_has(ct);
        exp_f = ck && !m_has(ct);
        n_cmp++;
        if (chk_hit !== exp_h || chk_fixup !== exp_f) begin
            n_bad++;
            $display("FAIL %s tag=%0d: hit,fixup=%b,%b expected %b,%b",
                     req, ct, chk_hit, chk_fixup, exp_h, exp_f);
        end
        @(posedge clk);
        if (fl) begin
            for (int i = 0; i < ENTRIES; i++) m_v[i] = 1'b0;
            m_ptr = 0;
        end else begin
            w = -1;
            if (ins) begin
                for (int i = 0; i < ENTRIES; i++)
                    if (w < 0 && m_v[i] && m_t[i] == it) w = i;
                for (int i = 0; i < ENTRIES; i++)
                    if (w < 0 && !m_v[i]) w = i;
                if (w < 0) begin
                    w = m_ptr;
                    m_ptr = (m_ptr + 1) % ENTRIES;
                end
            end
            if (st)
                for (int i = 0; i < ENTRIES; i++)
                    if (m_v[i] && m_g[i] == sa[ADDR_W-1:3]) m_v[i] = 1'b0;
            if (w >= 0) begin
                m_v[w] = !(st && ia[ADDR_W-1:3] == sa[ADDR_W-1:3]);
                m_t[w] = it;
                m_g[w] = ia[ADDR_W-1:3];
            end
        end
        @(negedge clk);
    endtask

    task automatic chk_all(input string req);
        for (int t = 0; t < NTAGS; t++) cyc(0, '0, '0, 0, '0, 0, 1, TAG_W'(t), req);
    endtask

    task automatic ins_op(input logic [TAG_W-1:0] t, input logic [ADDR_W-1:0] a, input string req);
        cyc(1, t, a, 0, '0, 0, 0, '0, req);
    endtask

    task automatic st_op(input logic [ADDR_W-1:0] a, input string req);
        cyc(0, '0, '0, 1, a, 0, 0, '0, req);
    endtask

    task automatic fl_op(input string req);
        cyc(0, '0, '0, 0, '0, 1, 0, '0, req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] lf;
        for (int i = 0; i < ENTRIES; i++) begin m_v[i] = 1'b0; m_t[i] = '0; m_g[i] = '0; end
        m_ptr = 0;
        rst = 1'b1; flush = 0; ins_valid = 0; ins_tag = '0; ins_addr = '0;
        st_valid = 0; st_addr = '0; chk_valid = 0; chk_tag = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset
        chk_all("R1");

        // R2, R5: insert then repeated hits
        ins_op(4'd3, 12'h100, "R2");
        chk_all("R2");
        cyc(0, '0, '0, 0, '0, 0, 1, 4'd3, "R5");
        cyc(0, '0, '0, 0, '0, 0, 1, 4'd3, "R5");

        // R3: same granule with differing low bits kills, other granule does not
        st_op(12'h107, "R3");
        chk_all("R3");
        ins_op(4'd3, 12'h100, "R3");
        st_op(12'h108, "R3");
        chk_all("R3");

        // R4: one store kills all entries in its granule
        ins_op(4'd5, 12'h200, "R4");
        ins_op(4'd6, 12'h203, "R4");
        ins_op(4'd7, 12'h300, "R4");
        st_op(12'h204, "R4");
        chk_all("R4");

        // R6: same tag replaces in place
        ins_op(4'd3, 12'h400, "R6");
        st_op(12'h100, "R6");
        chk_all("R6");
        st_op(12'h400, "R6");
        chk_all("R6");

        // R9: flush empties, wins over same-cycle insert, resets pointer
        ins_op(4'd12, 12'h500, "R9");
        cyc(1, 4'd11, 12'h510, 0, '0, 1, 0, '0, "R9");
        chk_all("R9");

        // R7: round-robin eviction once full
        ins_op(4'd1, 12'h010, "R7");
        ins_op(4'd2, 12'h020, "R7");
        ins_op(4'd3, 12'h030, "R7");
        ins_op(4'd4, 12'h040, "R7");
        ins_op(4'd1, 12'h018, "R6");
        chk_all("R6");
        ins_op(4'd5, 12'h050, "R7");
        ins_op(4'd6, 12'h060, "R7");
        chk_all("R7");
        ins_op(4'd7, 12'h070, "R7");
        ins_op(4'd8, 12'h080, "R7");
        ins_op(4'd9, 12'h090, "R7");
        chk_all("R7");

        // R11: freed slot reused before eviction
        st_op(12'h070, "R11");
        ins_op(4'd10, 12'h0a0, "R11");
        chk_all("R11");

        // R8: insert and store in one cycle
        fl_op("R8");
        cyc(1, 4'd9, 12'h500, 1, 12'h503, 0, 0, '0, "R8");
        cyc(1, 4'd10, 12'h600, 1, 12'h700, 0, 0, '0, "R8");
        chk_all("R8");

        // R10: check sees pre-update state; idle outputs low
        ins_op(4'd2, 12'h080, "R10");
        cyc(0, '0, '0, 1, 12'h080, 0, 1, 4'd2, "R10");
        cyc(0, '0, '0, 0, '0, 0, 1, 4'd2, "R10");
        cyc(1, 4'd13, 12'h0c0, 0, '0, 0, 1, 4'd13, "R10");
        cyc(0, '0, '0, 0, '0, 0, 0, 4'd13, "R10");

        // R2, R3, R7, R8: pseudo-random mix against the model
        lf = 32'h1ace_b00c;
        for (int n = 0; n < 4000; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            cyc(lf[0], lf[15:12], {6'b0, lf[10:5]}, lf[1], {6'b0, lf[29:24]},
                (lf[20:16] == 5'd0), lf[2], lf[19:16] ^ lf[23:20], "R2");
        end
        chk_all("R7");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule